// File: doc/BRIEF.md
# Display Peripheral Read-Response Parser

After a bus turnaround, a display peripheral answers the host with a short run of 32-bit words that land in a read FIFO. This block takes that run as a stream of words. The first word is the trigger status. The second word is a packet header, and any later words are payload. The block first classifies the status word. It then uses the 6-bit data type in the header to choose one of three paths: an acknowledge-with-error-report path, a short-read path that returns one or two bytes, or a long-read path that unpacks payload words into bytes.

Every byte that leaves the block goes out on a valid/ready byte port, and the final byte carries a last flag. The number of bytes delivered never exceeds the programmed receive limit. Once every word of the run has been consumed, whether used or discarded, a single-cycle done pulse presents the delivered byte count. A data type outside the handled set raises a protocol-error flag and produces no bytes.

A run begins with a start pulse. The pulse carries the number of words waiting in the FIFO, as read from the 5-bit fill count, and the receive limit.

Top module: `rsp_parser`

## Requirements
- R1: After reset the block is idle: busy, done, out_valid and in_ready are all low.
- R2: The first word of a run is the trigger status: exactly 32'h00000084 sets ack_seen, exactly 32'h00000087 sets esc_seen, and any other value sets status_unknown; at most one of the three is high.
- R3: The header data type is header bits [5:0]; type 6'h02 is an acknowledge-with-error-report whose 16-bit error vector (bit 0 SoT error up to bit 15 protocol violation) is header bits [23:8], shown on err_vec with err_report_valid high and zero bytes delivered.
- R4: Type 6'h21 delivers one byte taken from header bits [15:8]; type 6'h22 delivers header bits [15:8] first and then header bits [23:16].
- R5: Types 6'h1A and 6'h1C take a byte count from header bits [23:8] and deliver the bytes from the payload words that follow, bits [7:0] of each word first and bits [31:24] last.
- R6: The number of bytes delivered is the smallest of the decoded size, rx_limit, and (for long reads) four times the number of payload words; a limit of zero delivers nothing.
- R7: Any other header data type sets proto_err, delivers no bytes and reports a count of 0.
- R8: A run consumes exactly start_words input words, including payload words beyond the limit; start_words of 0 or 1 delivers no bytes. in_ready and out_valid are never high together.
- R9: out_data and out_last hold while out_valid is high and out_ready is low; out_last marks only the final byte, and out_valid is low in the cycle after it is taken.
- R10: done is high for exactly one cycle per run, with done_count equal to the number of bytes delivered; a start pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin parsing a run (taken only when idle) |
| start_words | input | CNT_W | Words waiting in the read FIFO |
| rx_limit | input | 16 | Receive length limit in bytes |
| in_valid | input | 1 | Word available from the FIFO |
| in_data | input | 32 | FIFO word |
| in_ready | output | 1 | Block takes the word this cycle |
| out_valid | output | 1 | Byte available |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final byte of the response |
| out_ready | input | 1 | Consumer takes the byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| done_count | output | 16 | Bytes delivered in the run |
| ack_seen | output | 1 | Status word was acknowledge |
| esc_seen | output | 1 | Status word was escape |
| status_unknown | output | 1 | Status word was neither |
| err_report_valid | output | 1 | Header was an error report |
| err_vec | output | 16 | Error-report vector |
| proto_err | output | 1 | Header data type not handled |

## Verification
The bench builds the block with CNT_W at its default of 5. That width is enough for the status-only, header-only and multi-word payload runs used here, and it also lets a run carry more payload words than the receive limit allows, so the draining of discarded words becomes visible. The byte consumer runs either always ready or stalled two cycles out of three. Under stalls, the ordering of bytes inside a lane and the holding of data both come into play.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int RSP_LEN_W = 16;

  localparam logic [5:0] DT_ACK_ERR   = 6'h02;
  localparam logic [5:0] DT_GEN_LONG  = 6'h1A;
  localparam logic [5:0] DT_DCS_LONG  = 6'h1C;
  localparam logic [5:0] DT_DCS_SHRT1 = 6'h21;
  localparam logic [5:0] DT_DCS_SHRT2 = 6'h22;

  localparam logic [31:0] STAT_ACK = 32'h0000_0084;
  localparam logic [31:0] STAT_ESC = 32'h0000_0087;

  typedef enum logic [1:0] {K_ERR, K_SHORT, K_LONG, K_BAD} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_STAT, S_HDR, S_PAY, S_EMIT, S_DONE} state_e;

  function automatic logic [RSP_LEN_W-1:0] clip_len(input logic [RSP_LEN_W-1:0] want,
                                                     input logic [RSP_LEN_W-1:0] lim);
    return (want < lim) ? want : lim;
  endfunction

  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    logic [31:0] sh;
    sh = w >> {lane, 3'b000};
    return sh[7:0];
  endfunction
endpackage

// File: rtl/rsp_hdr_decode.sv
module rsp_hdr_decode
  import rsp_pkg::*;
(
  input  logic [5:0]           dtype,
  input  logic [15:0]          field,
  input  logic [RSP_LEN_W-1:0] limit,
  output kind_e                kind,
  output logic [RSP_LEN_W-1:0] take_bytes
);
  always_comb begin
    kind       = K_BAD;
    take_bytes = '0;
    case (dtype)
      DT_ACK_ERR:   kind = K_ERR;
      DT_DCS_SHRT1: begin kind = K_SHORT; take_bytes = clip_len(16'd1, limit); end
      DT_DCS_SHRT2: begin kind = K_SHORT; take_bytes = clip_len(16'd2, limit); end
      DT_GEN_LONG,
      DT_DCS_LONG:  begin kind = K_LONG;  take_bytes = clip_len(field, limit); end
      default:      kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/rsp_byte_pick.sv
module rsp_byte_pick
  import rsp_pkg::*;
(
  input  logic [31:0]          word,
  input  logic [1:0]           lane,
  input  logic [RSP_LEN_W-1:0] bytes_left,
  input  logic                 no_more_words,
  output logic [7:0]           byte_out,
  output logic                 lane_end,
  output logic                 last
);
  logic final_byte;
  assign final_byte = (bytes_left == 16'd1);
  assign byte_out   = lane_byte(word, lane);
  assign lane_end   = final_byte || (lane == 2'd3);
  assign last       = final_byte || ((lane == 2'd3) && no_more_words);
endmodule

// File: rtl/rsp_parser.sv
module rsp_parser
  import rsp_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     start_words,
  input  logic [RSP_LEN_W-1:0] rx_limit,
  input  logic                 in_valid,
  input  logic [31:0]          in_data,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [7:0]           out_data,
  output logic                 out_last,
  input  logic                 out_ready,
  output logic                 busy,
  output logic                 done,
  output logic [RSP_LEN_W-1:0] done_count,
  output logic                 ack_seen,
  output logic                 esc_seen,
  output logic                 status_unknown,
  output logic                 err_report_valid,
  output logic [15:0]          err_vec,
  output logic                 proto_err
);
  state_e               st;
  logic [CNT_W-1:0]     words_left;
  logic [CNT_W-1:0]     words_rem;
  logic [RSP_LEN_W-1:0] bytes_left;
  logic [RSP_LEN_W-1:0] sent;
  logic [31:0]          lane_buf;
  logic [1:0]           lane;

  kind_e                hdr_kind;
  logic [RSP_LEN_W-1:0] hdr_bytes;
  logic                 lane_end;

  // named events used by the checker
  logic accept_start, take_word, emit_fire;

  rsp_hdr_decode u_dec (
    .dtype      (in_data[5:0]),
    .field      (in_data[23:8]),
    .limit      (rx_limit),
    .kind       (hdr_kind),
    .take_bytes (hdr_bytes)
  );

  rsp_byte_pick u_pick (
    .word          (lane_buf),
    .lane          (lane),
    .bytes_left    (bytes_left),
    .no_more_words (words_left == '0),
    .byte_out      (out_data),
    .lane_end      (lane_end),
    .last          (out_last)
  );

  assign in_ready     = (st == S_STAT) || (st == S_HDR) || (st == S_PAY);
  assign out_valid    = (st == S_EMIT);
  assign busy         = (st != S_IDLE);
  assign done         = (st == S_DONE);
  assign done_count   = sent;
  assign accept_start = start && (st == S_IDLE);
  assign take_word    = in_valid && in_ready;
  assign emit_fire    = out_valid && out_ready;
  assign words_rem    = words_left - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st               <= S_IDLE;
      words_left       <= '0;
      bytes_left       <= '0;
      sent             <= '0;
      lane_buf         <= '0;
      lane             <= '0;
      ack_seen         <= 1'b0;
      esc_seen         <= 1'b0;
      status_unknown   <= 1'b0;
      err_report_valid <= 1'b0;
      err_vec          <= '0;
      proto_err        <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept_start) begin
          ack_seen         <= 1'b0;
          esc_seen         <= 1'b0;
          status_unknown   <= 1'b0;
          err_report_valid <= 1'b0;
          err_vec          <= '0;
          proto_err        <= 1'b0;
          sent             <= '0;
          bytes_left       <= '0;
          words_left       <= start_words;
          st               <= (start_words == '0) ? S_DONE : S_STAT;
        end
        S_STAT: if (take_word) begin
          words_left     <= words_rem;
          ack_seen       <= (in_data == STAT_ACK);
          esc_seen       <= (in_data == STAT_ESC);
          status_unknown <= (in_data != STAT_ACK) && (in_data != STAT_ESC);
          st             <= (words_rem == '0) ? S_DONE : S_HDR;
        end
        S_HDR: if (take_word) begin
          words_left <= words_rem;
          lane_buf   <= {8'h00, in_data[31:8]};
          lane       <= '0;
          bytes_left <= hdr_bytes;
          if (hdr_kind == K_ERR) begin
            err_report_valid <= 1'b1;
            err_vec          <= in_data[23:8];
          end
          if (hdr_kind == K_BAD) proto_err <= 1'b1;
          if ((hdr_kind == K_SHORT) && (hdr_bytes != '0)) st <= S_EMIT;
          else if (words_rem != '0)                       st <= S_PAY;
          else                                            st <= S_DONE;
        end
        S_PAY: if (take_word) begin
          words_left <= words_rem;
          lane_buf   <= in_data;
          lane       <= '0;
          if (bytes_left != '0)     st <= S_EMIT;
          else if (words_rem == '0) st <= S_DONE;
        end
        S_EMIT: if (emit_fire) begin
          bytes_left <= bytes_left - 1'b1;
          sent       <= sent + 1'b1;
          lane       <= lane + 1'b1;
          if (lane_end) st <= (words_left != '0) ? S_PAY : S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_parser_chk.sv
module rsp_parser_chk
  import rsp_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [7:0]           out_data,
  input logic                 out_last,
  input logic                 done,
  input logic [RSP_LEN_W-1:0] done_count,
  input logic                 ack_seen,
  input logic                 esc_seen,
  input logic                 status_unknown,
  input logic                 err_report_valid,
  input logic                 proto_err,
  input logic                 accept_start,
  input logic                 emit_fire
);
  logic [RSP_LEN_W-1:0] seen_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_bytes <= '0;
    else if (accept_start) seen_bytes <= '0;
    else if (emit_fire)    seen_bytes <= seen_bytes + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  assert_status_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_seen, esc_seen, status_unknown}));

  assert_err_no_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_report_valid) |-> (done_count == '0));

  assert_proto_no_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && proto_err) |-> (done_count == '0));

  assert_one_side_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  assert_count_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count == seen_bytes));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rsp_parser rsp_parser_chk u_rsp_parser_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .busy             (busy),
  .in_ready         (in_ready),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .out_last         (out_last),
  .done             (done),
  .done_count       (done_count),
  .ack_seen         (ack_seen),
  .esc_seen         (esc_seen),
  .status_unknown   (status_unknown),
  .err_report_valid (err_report_valid),
  .proto_err        (proto_err),
  .accept_start     (accept_start),
  .emit_fire        (emit_fire)
);

// File: tb/rsp_parser_bench.sv
`timescale 1ns/1ps
module rsp_parser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  start_words = '0;
  logic [15:0] rx_limit = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_last;
  logic        out_ready = 1'b1;
  logic        busy, done, ack_seen, esc_seen, status_unknown, err_report_valid, proto_err;
  logic [15:0] done_count, err_vec;

  always #2.5 clk = ~clk;

  rsp_parser #(.CNT_W(5)) u_rsp_parser (
    .clk(clk), .rst_n(rst_n), .start(start), .start_words(start_words), .rx_limit(rx_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
    .busy(busy), .done(done), .done_count(done_count),
    .ack_seen(ack_seen), .esc_seen(esc_seen), .status_unknown(status_unknown),
    .err_report_valid(err_report_valid), .err_vec(err_vec), .proto_err(proto_err)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] wq [0:15];
  int nw = 0, fp = 0, ng = 0, done_cycles = 0;
  bit feeding = 0, stall = 0, done_seen = 0;
  bit pend_in = 0, pend_out = 0, pend_last = 0;
  logic [7:0] pend_byte = '0;
  logic [7:0] got [0:63];
  bit got_last [0:63];
  logic [15:0] cap_count = '0, cap_evec = '0;
  bit cap_ack = 0, cap_esc = 0, cap_unk = 0, cap_errv = 0, cap_perr = 0;

  logic [7:0] exp_b [0:63];
  int exp_n = 0;
  bit exp_ack = 0, exp_esc = 0, exp_unk = 0, exp_errv = 0, exp_perr = 0;
  logic [15:0] exp_evec = '0;

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // stimulus and capture, all away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (pend_in) fp++;
    if (pend_out) begin
      if (ng < 64) begin got[ng] = pend_byte; got_last[ng] = pend_last; end
      ng++;
    end
    in_valid  = feeding && (fp < nw);
    in_data   = (fp < nw && fp < 16) ? wq[fp] : 32'h0;
    out_ready = stall ? ((cyc % 3) == 0) : 1'b1;
    pend_in   = in_valid && in_ready;
    pend_out  = out_valid && out_ready;
    pend_byte = out_data;
    pend_last = out_last;
    if (done) begin
      done_cycles++;
      done_seen = 1;
      cap_count = done_count; cap_ack = ack_seen; cap_esc = esc_seen; cap_unk = status_unknown;
      cap_errv = err_report_valid; cap_evec = err_vec; cap_perr = proto_err;
    end
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // expected behaviour computed from the requirements
  task automatic model(input int n, input logic [15:0] lim);
    int sz, avail;
    logic [5:0] dt;
    exp_n = 0; exp_errv = 0; exp_perr = 0; exp_evec = '0;
    exp_ack = (n >= 1) && (wq[0] == 32'h84);
    exp_esc = (n >= 1) && (wq[0] == 32'h87);
    exp_unk = (n >= 1) && !exp_ack && !exp_esc;
    if (n >= 2) begin
      dt = wq[1][5:0];
      if (dt == 6'h02) begin
        exp_errv = 1; exp_evec = wq[1][23:8];
      end else if (dt == 6'h21 || dt == 6'h22) begin
        sz = (dt == 6'h21) ? 1 : 2;
        if (int'(lim) < sz) sz = int'(lim);
        for (int i = 0; i < sz; i++) exp_b[i] = wq[1][8 + 8*i +: 8];
        exp_n = sz;
      end else if (dt == 6'h1A || dt == 6'h1C) begin
        sz = int'(wq[1][23:8]);
        if (int'(lim) < sz) sz = int'(lim);
        avail = 4 * (n - 2);
        if (avail < sz) sz = avail;
        for (int i = 0; i < sz; i++) exp_b[i] = wq[2 + i/4][8*(i%4) +: 8];
        exp_n = sz;
      end else begin
        exp_perr = 1;
      end
    end
  endtask

  task automatic run(input int n, input logic [15:0] lim, input bit stl, input bit dbl);
    model(n, lim);
    @(negedge clk);
    nw = n; fp = 0; ng = 0; done_cycles = 0; done_seen = 0;
    stall = stl; feeding = 1; rx_limit = lim;
    start = 1; start_words = n[4:0];
    @(negedge clk);
    start = 0;
    if (dbl) begin
      @(negedge clk); start = 1; start_words = 5'd0;
      @(negedge clk); start = 0;
    end
    for (int k = 0; k < 2000 && !done_seen; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    feeding = 0;
  endtask

  task automatic verify(input string req);
    check(done_seen, "R10", {req, " done seen"}, done_seen, 1);
    check(done_cycles == 1, "R10", "done pulse width", done_cycles, 1);
    check(fp == nw, "R8", {req, " words consumed"}, fp, nw);
    check(ng == exp_n, req, "bytes delivered", ng, exp_n);
    check(cap_count == exp_n[15:0], "R10", {req, " done_count"}, cap_count, exp_n);
    for (int i = 0; i < exp_n && i < ng; i++) begin
      check(got[i] == exp_b[i], req, $sformatf("byte %0d", i), got[i], exp_b[i]);
      check(got_last[i] == (i == exp_n - 1), "R9", $sformatf("%s last flag %0d", req, i),
            got_last[i], (i == exp_n - 1));
    end
    check({cap_ack, cap_esc, cap_unk} == {exp_ack, exp_esc, exp_unk}, "R2",
          {req, " status class"}, {cap_ack, cap_esc, cap_unk}, {exp_ack, exp_esc, exp_unk});
    check(cap_errv == exp_errv && cap_evec == exp_evec, "R3", {req, " error report"},
          {cap_errv, cap_evec}, {exp_errv, exp_evec});
    check(cap_perr == exp_perr, "R7", {req, " protocol error"}, cap_perr, exp_perr);
  endtask

  task automatic t_reset_R1();
    check(!busy && !done && !out_valid && !in_ready, "R1", "idle after reset",
          {busy, done, out_valid, in_ready}, 0);
  endtask

  task automatic t_status_only_R2();
    wq[0] = 32'h84;
    run(1, 16'd8, 0, 0); verify("R2");
    wq[0] = 32'h1234_5678;
    run(1, 16'd8, 0, 0); verify("R2");
  endtask

  task automatic t_err_report_R3();
    wq[0] = 32'h87; wq[1] = 32'h00C3_A502;
    run(2, 16'd8, 0, 0); verify("R3");
    wq[0] = 32'h84; wq[1] = 32'h0080_0102; wq[2] = 32'hDEAD_BEEF;
    run(3, 16'd8, 0, 0); verify("R3");
  endtask

  task automatic t_short_R4();
    wq[0] = 32'h84; wq[1] = 32'h0000_AB21;
    run(2, 16'd4, 0, 0); verify("R4");
    wq[1] = 32'h0077_3C22;
    run(2, 16'd4, 1, 0); verify("R4");
  endtask

  task automatic t_long_R5();
    wq[0] = 32'h84; wq[1] = 32'h0000_061C; wq[2] = 32'h4433_2211; wq[3] = 32'h8877_6655;
    run(4, 16'd16, 0, 0); verify("R5");
    wq[1] = 32'h0000_081A; wq[2] = 32'hA3A2_A1A0; wq[3] = 32'hB3B2_B1B0;
    run(4, 16'd8, 1, 0); verify("R5");
  endtask

  task automatic t_clip_R6();
    wq[0] = 32'h84; wq[1] = 32'h0000_5622;
    run(2, 16'd1, 0, 0); verify("R6");
    wq[1] = 32'h0000_0A1A; wq[2] = 32'h0403_0201; wq[3] = 32'h0807_0605; wq[4] = 32'h0C0B_0A09;
    run(5, 16'd5, 1, 0); verify("R6");
    run(5, 16'd0, 0, 0); verify("R6");
  endtask

  task automatic t_bad_type_R7();
    wq[0] = 32'h0000_0099; wq[1] = 32'h00FF_FF15; wq[2] = 32'h1111_2222;
    run(3, 16'd8, 0, 0); verify("R7");
  endtask

  task automatic t_zero_words_R8();
    run(0, 16'd8, 0, 0); verify("R8");
  endtask

  task automatic t_busy_start_R10();
    wq[0] = 32'h84; wq[1] = 32'h0000_0C1C;
    wq[2] = 32'h1312_1110; wq[3] = 32'h1716_1514; wq[4] = 32'h1B1A_1918;
    run(5, 16'd12, 1, 1); verify("R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_status_only_R2();
    t_err_report_R3();
    t_short_R4();
    t_long_R5();
    t_clip_R6();
    t_bad_type_R7();
    t_zero_words_R8();
    t_busy_start_R10();
    repeat (4) @(negedge clk);
    summary_and_end();
  end
endmodule